// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block lets a processor core run table-style byte reads and writes against external Flash, EPROM or SRAM over one set of shared address/data lines. The core raises a request carrying a byte address, a read/write flag, a latch select (low or high byte latch) and one data byte. It holds the request until `done` pulses for one cycle. Read data appears on `rdata` in that same cycle.

Every bus transfer has three parts. First comes a single address cycle, in which `ale` is high and all address lines are driven. Next comes a data phase, one cycle long plus the programmed wait count. Last comes a single turnaround cycle, in which nothing is driven and `done` is high. A static strap chooses between a 16-bit data width and a multiplexed 8-bit data width. It may change only while reset is held. In 16-bit mode, a two-bit write-mode field chooses how a byte write is presented to the memory: separate high/low write strobes, one high strobe plus upper/lower byte selects, or a word write that pairs a previously stored low byte with the high byte. All strobes and selects are active-high. A bus-disable bit hands the pins back as general-purpose I/O.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, `pins_io`, `done`, `ale`, `oe` and every write strobe are 0, and no line enable in `ad_oe` is set.
- R2: Control bits 7, 5, 4, 1 and 0 are writable. Bits 6, 3 and 2 always read back as 0.
- R3: While control bit 7 is 1, `pins_io` is 1 and no line enable, `ale`, `oe` or write strobe is asserted. A request then finishes with `done` in the cycle after it is accepted, and a read returns 0.
- R4: A bus transfer is exactly one `ale` cycle, in which all 20 lines are driven with the request address. The data phase follows, and then one turnaround cycle in which `done` is 1 and no line is driven. During the data phase, lines above the data width keep the address.
- R5: Control bits 5:4 select the data-phase length as 1 plus the wait count. The field values 11, 10, 01 and 00 give wait counts of 0, 1, 2 and 3.
- R6: A read holds `oe` high for the whole data phase with the data lines released. The data is sampled in the last data cycle. In 16-bit mode, address bit 0 = 1 returns lines 15:8 and address bit 0 = 0 returns lines 7:0. In 8-bit mode, lines 7:0 are returned.
- R7: In 8-bit mode a write drives the byte on lines 7:0 and asserts only `wrl` for the whole data phase, whatever the write-mode bits hold and whichever latch is selected.
- R8: In 16-bit mode with write mode 00, the byte appears on both halves of lines 15:0. `wrh` is asserted when address bit 0 is 1 and `wrl` when it is 0. `ub` and `lb` stay low.
- R9: In 16-bit mode with write mode 01, the byte appears on both halves. `wrh` is asserted, together with `ub` when address bit 0 is 1 or `lb` when it is 0.
- R10: In 16-bit mode with write mode 1x, a low-latch write only stores its byte and finishes with no bus activity. A high-latch write drives {high byte, stored low byte} on lines 15:0 with `wrh`, `ub` and `lb` asserted.
- R11: `ale`, `oe` and the write strobes never overlap in time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_bus | input | 1 | Static strap: 1 = 16-bit data, 0 = multiplexed 8-bit data |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 8 | Control register write value |
| ctl_rdata | output | 8 | Control register read value |
| req | input | 1 | Transfer request, held until `done` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_hi | input | 1 | Write targets the high byte latch |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 8 | Write byte |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read byte, valid with `done` |
| ad_in | input | 16 | Data lines as seen from the pins |
| ad_out | output | 20 | Values driven onto the shared lines |
| ad_oe | output | 20 | Per-line output enable |
| ale | output | 1 | Address latch strobe |
| oe | output | 1 | Memory output enable |
| wrh | output | 1 | High write strobe |
| wrl | output | 1 | Low write strobe |
| ub | output | 1 | Upper byte select |
| lb | output | 1 | Lower byte select |
| pins_io | output | 1 | Pins returned to general-purpose I/O |

## Verification
The bench steps the wait field through all four codes and counts the data-phase cycles of each. A design that decoded the field in the forward order would stretch the 11 setting to three waits instead of none. For each write mode, it writes to both an even and an odd address and then reads the bytes back from an SRAM model that decodes strobes the way a real part does. A swapped `ub`/`lb` choice or a wrong `wrh`/`wrl` choice leaves the wrong byte changed, and the readback exposes it. It sends a low-latch write in word mode and checks that no `ale` appears. A controller that started a bus cycle there would write a half-formed word. It also runs 8-bit mode with a nonzero write mode, where leaked write-mode logic would pulse `wrh`.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_TURN = 2'd3
  } phase_t;

  localparam int CTL_W    = 8;
  localparam int OFF_BIT  = 7;
  localparam int WAIT_MSB = 5;
  localparam int WAIT_LSB = 4;
  localparam int MODE_MSB = 1;
  localparam int MODE_LSB = 0;
  localparam logic [CTL_W-1:0] CTL_MASK = 8'hB3;

  // wait field counts downward: all-ones means no extra cycles
  function automatic logic [1:0] wait_from_field(input logic [1:0] f);
    return ~f;
  endfunction

endpackage

// File: rtl/xbus_ctlreg.sv
module xbus_ctlreg
  import xbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] rdata,
  output logic             bus_off,
  output logic [1:0]       wait_cnt,
  output logic [1:0]       wmode
);

  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (rst)     ctl_q <= '0;
    else if (we) ctl_q <= wdata & CTL_MASK;
  end

  assign rdata    = ctl_q;
  assign bus_off  = ctl_q[OFF_BIT];
  assign wait_cnt = wait_from_field(ctl_q[WAIT_MSB:WAIT_LSB]);
  assign wmode    = ctl_q[MODE_MSB:MODE_LSB];

  assert_readback_R2: assert property (@(posedge clk) disable iff (rst)
    we |=> rdata == ($past(wdata) & CTL_MASK));

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              bus_ok,
  input  logic [WAIT_W-1:0] wait_cnt,
  output phase_t            phase_q,
  output logic              start,
  output logic              bypass,
  output logic              last_data
);

  logic [WAIT_W-1:0] cnt_q;
  logic [WAIT_W-1:0] len_q;
  logic [WAIT_W-1:0] wait_cap;

  assign start     = (phase_q == PH_IDLE) && req && bus_ok;
  assign bypass    = (phase_q == PH_IDLE) && req && !bus_ok;
  assign last_data = (phase_q == PH_DATA) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_ADDR;
            cnt_q   <= wait_cnt;
          end else if (bypass) begin
            phase_q <= PH_TURN;
          end
        end
        PH_ADDR: phase_q <= PH_DATA;
        PH_DATA: begin
          if (cnt_q == '0) phase_q <= PH_TURN;
          else             cnt_q   <= cnt_q - WAIT_W'(1);
        end
        PH_TURN: phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // independent length counter for the data-phase check
  always_ff @(posedge clk) begin
    if (rst) begin
      len_q    <= '0;
      wait_cap <= '0;
    end else if (start) begin
      len_q    <= '0;
      wait_cap <= wait_cnt;
    end else if (phase_q == PH_DATA) begin
      len_q <= len_q + WAIT_W'(1);
    end
  end

  assert_wait_len_R5: assert property (@(posedge clk) disable iff (rst)
    last_data |-> len_q == wait_cap);

  assert_addr_once_R4: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_ADDR |=> phase_q == PH_DATA);

  assert_turn_once_R4: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_TURN |=> phase_q == PH_IDLE);

endmodule

// File: rtl/xbus_datapath.sv
module xbus_datapath #(
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8,
  localparam int DATA_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              bypass,
  input  logic              last_data,
  input  logic              wide,
  input  logic [1:0]        wmode,
  input  logic              req_we,
  input  logic              req_hi,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic [ADDR_W-1:0] op_addr,
  output logic              op_we,
  output logic [DATA_W-1:0] op_data,
  output logic              op_wrh,
  output logic              op_wrl,
  output logic              op_ub,
  output logic              op_lb,
  output logic [BYTE_W-1:0] rdata
);

  logic [BYTE_W-1:0] lo_q;
  logic [DATA_W-1:0] data_d;
  logic              wrh_d, wrl_d, ub_d, lb_d;
  logic              a0;
  logic              accept;

  assign a0     = req_addr[0];
  assign accept = start || bypass;

  always_comb begin
    data_d = {req_wdata, req_wdata};
    wrh_d  = 1'b0;
    wrl_d  = 1'b0;
    ub_d   = 1'b0;
    lb_d   = 1'b0;
    if (!wide) begin
      data_d = {{BYTE_W{1'b0}}, req_wdata};
      wrl_d  = req_we;
    end else if (req_we) begin
      if (wmode[1]) begin
        data_d = {req_wdata, lo_q};
        wrh_d  = 1'b1;
        ub_d   = 1'b1;
        lb_d   = 1'b1;
      end else if (wmode[0]) begin
        wrh_d = 1'b1;
        ub_d  = a0;
        lb_d  = !a0;
      end else begin
        wrh_d = a0;
        wrl_d = !a0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_addr <= '0;
      op_we   <= 1'b0;
      op_data <= '0;
      op_wrh  <= 1'b0;
      op_wrl  <= 1'b0;
      op_ub   <= 1'b0;
      op_lb   <= 1'b0;
    end else if (start) begin
      op_addr <= req_addr;
      op_we   <= req_we;
      op_data <= data_d;
      op_wrh  <= wrh_d;
      op_wrl  <= wrl_d;
      op_ub   <= ub_d;
      op_lb   <= lb_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                            lo_q <= '0;
    else if (accept && req_we && !req_hi) lo_q <= req_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (bypass && !req_we) begin
      rdata <= '0;
    end else if (last_data && !op_we) begin
      if (wide && op_addr[0]) rdata <= ad_in[DATA_W-1:BYTE_W];
      else                    rdata <= ad_in[BYTE_W-1:0];
    end
  end

  assert_low_latch_R10: assert property (@(posedge clk) disable iff (rst)
    (accept && req_we && !req_hi) |=> lo_q == $past(req_wdata));

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8,
  localparam int DATA_W = 2 * BYTE_W
) (
  input  phase_t            phase_q,
  input  logic              bus_off,
  input  logic              wide,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              op_we,
  input  logic [DATA_W-1:0] op_data,
  input  logic              op_wrh,
  input  logic              op_wrl,
  input  logic              op_ub,
  input  logic              op_lb,
  output logic [ADDR_W-1:0] ad_out,
  output logic [ADDR_W-1:0] ad_oe,
  output logic              ale,
  output logic              oe,
  output logic              wrh,
  output logic              wrl,
  output logic              ub,
  output logic              lb
);

  localparam logic [ADDR_W-1:0] WIDE_M   = ADDR_W'({DATA_W{1'b1}});
  localparam logic [ADDR_W-1:0] NARROW_M = ADDR_W'({BYTE_W{1'b1}});

  logic [ADDR_W-1:0] dmask;
  assign dmask = wide ? WIDE_M : NARROW_M;

  always_comb begin
    ad_out = '0;
    ad_oe  = '0;
    ale    = 1'b0;
    oe     = 1'b0;
    wrh    = 1'b0;
    wrl    = 1'b0;
    ub     = 1'b0;
    lb     = 1'b0;
    if (!bus_off) begin
      unique case (phase_q)
        PH_ADDR: begin
          ad_out = op_addr;
          ad_oe  = '1;
          ale    = 1'b1;
        end
        PH_DATA: begin
          ad_out = (op_addr & ~dmask) | (ADDR_W'(op_data) & dmask);
          ad_oe  = op_we ? '1 : ~dmask;
          oe     = !op_we;
          wrh    = op_wrh;
          wrl    = op_wrl;
          ub     = op_ub;
          lb     = op_lb;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8,
  localparam int DATA_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_bus,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  input  logic              req,
  input  logic              req_we,
  input  logic              req_hi,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              done,
  output logic [BYTE_W-1:0] rdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic [ADDR_W-1:0] ad_out,
  output logic [ADDR_W-1:0] ad_oe,
  output logic              ale,
  output logic              oe,
  output logic              wrh,
  output logic              wrl,
  output logic              ub,
  output logic              lb,
  output logic              pins_io
);

  logic              bus_off;
  logic [1:0]        wait_cnt;
  logic [1:0]        wmode;
  phase_t            phase_q;
  logic              start, bypass, last_data, bus_ok, skip;
  logic [ADDR_W-1:0] op_addr;
  logic              op_we, op_wrh, op_wrl, op_ub, op_lb;
  logic [DATA_W-1:0] op_data;

  // word mode: a low-latch write only loads the latch
  assign skip    = wide_bus && wmode[1] && req_we && !req_hi;
  assign bus_ok  = !bus_off && !skip;
  assign done    = (phase_q == PH_TURN);
  assign pins_io = bus_off;

  xbus_ctlreg u_ctl (
    .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata), .rdata(ctl_rdata),
    .bus_off(bus_off), .wait_cnt(wait_cnt), .wmode(wmode)
  );

  xbus_seq #(.WAIT_W(2)) u_seq (
    .clk(clk), .rst(rst), .req(req), .bus_ok(bus_ok), .wait_cnt(wait_cnt),
    .phase_q(phase_q), .start(start), .bypass(bypass), .last_data(last_data)
  );

  xbus_datapath #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rst(rst), .start(start), .bypass(bypass), .last_data(last_data),
    .wide(wide_bus), .wmode(wmode), .req_we(req_we), .req_hi(req_hi),
    .req_addr(req_addr), .req_wdata(req_wdata), .ad_in(ad_in),
    .op_addr(op_addr), .op_we(op_we), .op_data(op_data), .op_wrh(op_wrh),
    .op_wrl(op_wrl), .op_ub(op_ub), .op_lb(op_lb), .rdata(rdata)
  );

  xbus_pins #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_pins (
    .phase_q(phase_q), .bus_off(bus_off), .wide(wide_bus), .op_addr(op_addr),
    .op_we(op_we), .op_data(op_data), .op_wrh(op_wrh), .op_wrl(op_wrl),
    .op_ub(op_ub), .op_lb(op_lb), .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale),
    .oe(oe), .wrh(wrh), .wrl(wrl), .ub(ub), .lb(lb)
  );

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ale, oe, wrh || wrl}));

  assert_released_R3: assert property (@(posedge clk) disable iff (rst)
    pins_io |-> (ad_oe == '0 && !ale && !oe && !wrh && !wrl));

  assert_turn_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> ad_oe == '0);

endmodule

// File: tb/xbus_ctrl_tb.sv
`timescale 1ns/1ps
module xbus_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide_bus = 1'b1;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [7:0]  ctl_rdata;
  logic        req = 1'b0, req_we = 1'b0, req_hi = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        done;
  logic [7:0]  rdata;
  logic [15:0] ad_in;
  logic [19:0] ad_out, ad_oe;
  logic        ale, oe, wrh, wrl, ub, lb, pins_io;

  always #2 clk = ~clk;

  xbus_ctrl u_dut (
    .clk(clk), .rst(rst), .wide_bus(wide_bus), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .req(req), .req_we(req_we),
    .req_hi(req_hi), .req_addr(req_addr), .req_wdata(req_wdata), .done(done),
    .rdata(rdata), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale),
    .oe(oe), .wrh(wrh), .wrl(wrl), .ub(ub), .lb(lb), .pins_io(pins_io)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // ---------------- SRAM model ----------------
  logic [19:0] lat_a = '0;
  logic [7:0]  m_hi [32];
  logic [7:0]  m_lo [32];
  logic [7:0]  m_8  [32];
  initial for (int i = 0; i < 32; i++) begin
    m_hi[i] = '0; m_lo[i] = '0; m_8[i] = '0;
  end

  assign ad_in = !oe ? 16'h0 :
                 wide_bus ? {m_hi[lat_a[5:1]], m_lo[lat_a[5:1]]} :
                            {8'h00, m_8[lat_a[4:0]]};

  always @(negedge clk) begin
    if (ale) lat_a <= ad_out;
    if (wide_bus) begin
      if ((wrh && !ub && !lb) || (wrh && ub)) m_hi[lat_a[5:1]] <= ad_out[15:8];
      if (wrl || (wrh && lb))                 m_lo[lat_a[5:1]] <= ad_out[7:0];
    end else if (wrl) begin
      m_8[lat_a[4:0]] <= ad_out[7:0];
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    string       tag;
    int          n_ale;
    int          n_data;
    logic [3:0]  strb;     // {wrh,wrl,ub,lb}
    bit          is_wr;
    logic [15:0] wdat;
    logic [15:0] wmask;
    bit          is_rd;
    logic [7:0]  rd;
  } exp_t;
  exp_t q[$];

  int         s_ale = 0, s_data = 0;
  logic [3:0] s_strb = '0;
  logic [15:0] s_dat = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (ale) s_ale++;
      if (wrh || wrl || oe) s_data++;
      s_strb = s_strb | {wrh, wrl, ub, lb};
      if (wrh || wrl) s_dat = ad_out[15:0];
      if (done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R4", "unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(s_ale == e.n_ale, e.tag, "ale cycles", s_ale, e.n_ale);
          chk(s_data == e.n_data, e.tag, "data cycles", s_data, e.n_data);
          chk(s_strb == e.strb, e.tag, "strobes", {28'd0, s_strb}, {28'd0, e.strb});
          chk(ad_oe == '0, "R4", "turnaround drive", {12'd0, ad_oe}, 32'd0);
          if (e.is_wr)
            chk((s_dat & e.wmask) == e.wdat, e.tag, "write data",
                {16'd0, s_dat & e.wmask}, {16'd0, e.wdat});
          if (e.is_rd)
            chk(rdata == e.rd, e.tag, "read data", {24'd0, rdata}, {24'd0, e.rd});
        end
        s_ale = 0; s_data = 0; s_strb = '0; s_dat = '0;
      end
    end
  end

  // ---------------- reference state ----------------
  bit         cur_off = 0;
  int         cur_wait = 3;
  logic [1:0] cur_mode = 2'b00;
  logic [7:0] r_hi [32];
  logic [7:0] r_lo [32];
  logic [7:0] r_8  [32];
  logic [7:0] lo_ref = '0;
  initial for (int i = 0; i < 32; i++) begin
    r_hi[i] = '0; r_lo[i] = '0; r_8[i] = '0;
  end

  task automatic set_ctl(input bit off, input int wt, input logic [1:0] md);
    @(negedge clk);
    ctl_we    = 1'b1;
    ctl_wdata = {off, 1'b0, 2'(3 - wt), 2'b00, md};
    @(negedge clk);
    ctl_we = 1'b0;
    cur_off = off; cur_wait = wt; cur_mode = md;
  endtask

  task automatic op(input bit we, input bit hi, input logic [19:0] a,
                    input logic [7:0] d, input string tag);
    exp_t e;
    bit   byp;
    int   idx;
    idx = wide_bus ? int'(a[5:1]) : int'(a[4:0]);
    byp = cur_off || (wide_bus && cur_mode[1] && we && !hi);
    e.tag = tag;
    e.n_ale = byp ? 0 : 1;
    e.n_data = byp ? 0 : cur_wait + 1;
    e.strb = '0; e.is_wr = 0; e.wdat = '0; e.wmask = 16'hFFFF;
    e.is_rd = !we; e.rd = '0;
    if (we) begin
      if (!hi) lo_ref = d;
      if (!byp) begin
        e.is_wr = 1;
        if (!wide_bus) begin
          e.strb = 4'b0100; e.wdat = {8'h00, d}; e.wmask = 16'h00FF;
          r_8[idx] = d;
        end else if (cur_mode[1]) begin
          e.strb = 4'b1011; e.wdat = {d, lo_ref};
          r_hi[idx] = d; r_lo[idx] = lo_ref;
        end else begin
          e.wdat = {d, d};
          if (cur_mode[0]) e.strb = a[0] ? 4'b1010 : 4'b1001;
          else             e.strb = a[0] ? 4'b1000 : 4'b0100;
          if (a[0]) r_hi[idx] = d; else r_lo[idx] = d;
        end
      end
    end else if (!cur_off) begin
      e.rd = !wide_bus ? r_8[idx] : (a[0] ? r_hi[idx] : r_lo[idx]);
    end
    q.push_back(e);
    @(negedge clk);
    req = 1'b1; req_we = we; req_hi = hi; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!done);
    req = 1'b0;
  endtask

  task automatic do_reset(input bit wide);
    @(negedge clk);
    rst = 1'b1; wide_bus = wide;
    cur_off = 0; cur_wait = 3; cur_mode = 2'b00; lo_ref = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    chk(q.size() == 0, "R4", "pending items", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    do_reset(1'b1);
    @(negedge clk);
    // R1 reset state
    chk(ctl_rdata == 8'h00, "R1", "ctl reset", ctl_rdata, 0);
    chk(pins_io == 1'b0, "R1", "pins_io reset", pins_io, 0);
    chk({done, ale, oe, wrh, wrl} == 5'b0, "R1", "strobes reset", {done, ale, oe, wrh, wrl}, 0);
    chk(ad_oe == '0, "R1", "ad_oe reset", ad_oe, 0);

    // R2 readback masking
    @(negedge clk); ctl_we = 1; ctl_wdata = 8'hFF;
    @(negedge clk); ctl_we = 0;
    chk(ctl_rdata == 8'hB3, "R2", "readback FF", ctl_rdata, 8'hB3);
    @(negedge clk); ctl_we = 1; ctl_wdata = 8'h4C;
    @(negedge clk); ctl_we = 0;
    chk(ctl_rdata == 8'h00, "R2", "readback 4C", ctl_rdata, 8'h00);

    // R8 byte-write mode, no wait
    set_ctl(0, 0, 2'b00);
    op(1, 0, 20'h00003, 8'hA5, "R8");
    op(1, 0, 20'h00002, 8'h3C, "R8");
    op(0, 0, 20'h00003, 8'h00, "R6");
    op(0, 0, 20'h00002, 8'h00, "R6");

    // R5 wait sweep, each code in turn
    for (int w = 0; w < 4; w++) begin
      set_ctl(0, w, 2'b00);
      op(0, 0, 20'hF0002, 8'h00, "R5");
      op(1, 0, 20'hA0001, 8'h40 + 8'(w), "R5");
    end

    // R9 byte-select mode
    set_ctl(0, 1, 2'b01);
    op(1, 0, 20'h00005, 8'h11, "R9");
    op(1, 0, 20'h00004, 8'h22, "R9");
    op(0, 0, 20'h00005, 8'h00, "R9");
    op(0, 0, 20'h00004, 8'h00, "R9");

    // R10 word mode (10 and 11)
    set_ctl(0, 0, 2'b10);
    op(1, 0, 20'h00006, 8'h77, "R10");
    op(1, 1, 20'h00007, 8'h88, "R10");
    op(0, 0, 20'h00006, 8'h00, "R10");
    op(0, 0, 20'h00007, 8'h00, "R10");
    set_ctl(0, 2, 2'b11);
    op(1, 0, 20'h00008, 8'h5E, "R10");
    op(1, 1, 20'h00009, 8'hE5, "R10");
    op(0, 0, 20'h00008, 8'h00, "R10");

    // R3 bus disabled
    set_ctl(1, 0, 2'b00);
    chk(pins_io == 1'b1, "R3", "pins_io", pins_io, 1);
    chk(ad_oe == '0, "R3", "ad_oe idle", ad_oe, 0);
    op(0, 0, 20'h00003, 8'h00, "R3");
    op(1, 0, 20'h00003, 8'hFF, "R3");
    set_ctl(0, 0, 2'b00);
    op(0, 0, 20'h00003, 8'h00, "R3");

    // R7 narrow mode, write mode bits set but ignored
    do_reset(1'b0);
    set_ctl(0, 1, 2'b01);
    op(1, 0, 20'h00009, 8'h5A, "R7");
    op(1, 1, 20'h0000A, 8'hC3, "R7");
    op(0, 0, 20'h00009, 8'h00, "R7");
    op(0, 0, 20'h0000A, 8'h00, "R7");
    set_ctl(0, 3, 2'b10);
    op(1, 0, 20'h0000B, 8'h9D, "R7");
    op(0, 0, 20'h0000B, 8'h00, "R6");

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule